// File: doc/BRIEF.md
# Bfloat16 Multiplier

This block multiplies two 16-bit brain-float operands (one sign bit, eight exponent bits, seven stored mantissa bits) and delivers a 16-bit brain-float product in the same cycle. It is purely combinational. It is meant to sit inside a wider datapath, such as a lane of a vector arithmetic unit, where the surrounding logic registers its operands and its result.

The result sign is the exclusive-or of the operand signs. Each significand is rebuilt with its hidden leading one, and the two 8-bit significands are multiplied into a 16-bit product. The biased exponents are added and one bias (127) is taken away. If the product has its top bit set, it is normalized by one right shift and the exponent is incremented. The bits below the seven kept mantissa bits are dropped without rounding.

A few edge rules keep the output well defined. An operand with exponent field zero counts as zero. A final exponent at or below zero flushes to a signed zero. A final exponent of 255 or more saturates to a signed infinity.

Top module: `bf16_multiplier`

## Requirements
- R1: Result bit 15 equals a[15] XOR b[15] for every operand pair, including results that are zero or infinity.
- R2: When the 16-bit product of the significands {1,a[6:0]} and {1,b[6:0]} has bit 15 clear, the result exponent (bits 14:7) is a[14:7] + b[14:7] - 127, and the result mantissa (bits 6:0) is product bits 13:7.
- R3: When that product has bit 15 set, the result exponent is a[14:7] + b[14:7] - 126, and the result mantissa is product bits 14:8.
- R4: Product bits below the kept mantissa field are discarded by truncation; no rounding increment is ever applied.
- R5: If either operand has exponent field 0, the result is signed zero: bits 14:0 are 0, whatever the other fields hold.
- R6: If the final exponent, counted after the normalization increment, is 0 or less, the result is signed zero. A final exponent of exactly 1 is kept.
- R7: If the final exponent is 255 or more, the result is signed infinity: exponent 8'hFF and mantissa 0. A final exponent of exactly 254 is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand, brain-float encoded |
| b | input | 16 | Second operand, brain-float encoded |
| result | output | 16 | Product, brain-float encoded, combinational |

## Verification
Directed pairs cover several cases, each chosen to tell one path from another. Exact powers of two take the unshifted path, while significands of 1.5 and above force the one-bit normalization. Mixed signs check the sign path. The smallest nonzero mantissas show that truncation drops the low bits instead of rounding. Exponent sums that land exactly on 0, 1, 254 and 255, both with and without the normalization carry, separate the flush and saturate thresholds from values that must survive, and show that the threshold test is made after the increment. Zero-exponent operands with nonzero mantissa fields confirm that such inputs count as zero. Several thousand seeded random pairs then cover the general case against an independent integer model.

// File: rtl/bf16_mul_pkg.sv
package bf16_mul_pkg;
  parameter int DEF_EXP_W = 8;
  parameter int DEF_MAN_W = 7;

  function automatic int exp_bias(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/bf16_unpack.sv
module bf16_unpack #(
  parameter int EXP_W = bf16_mul_pkg::DEF_EXP_W,
  parameter int MAN_W = bf16_mul_pkg::DEF_MAN_W,
  localparam int WIDTH = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1
) (
  input  logic [WIDTH-1:0] word,
  output logic             sign,
  output logic [EXP_W-1:0] expo,
  output logic [SIG_W-1:0] sig,
  output logic             is_zero
);
  always_comb begin
    sign    = word[WIDTH-1];
    expo    = word[WIDTH-2 -: EXP_W];
    sig     = {1'b1, word[MAN_W-1:0]};
    is_zero = (expo == '0);
  end
endmodule

// File: rtl/bf16_sig_mult.sv
module bf16_sig_mult #(
  parameter int SIG_W = bf16_mul_pkg::DEF_MAN_W + 1,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic [SIG_W-1:0]  sig_a,
  input  logic [SIG_W-1:0]  sig_b,
  output logic [PROD_W-1:0] prod
);
  logic [PROD_W-1:0] partial [SIG_W];

  for (genvar i = 0; i < SIG_W; i++) begin : g_pp
    assign partial[i] = sig_b[i] ? (PROD_W'(sig_a) << i) : '0;
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < SIG_W; i++) begin
      prod = prod + partial[i];
    end
  end

  // R3: both significands carry a hidden one, so the product lies in [1,4)
  always_comb begin
    if (!$isunknown({sig_a, sig_b})) begin
      assert_prod_range_R3: assert (!(sig_a[SIG_W-1] && sig_b[SIG_W-1]) ||
                                    (prod[PROD_W-1] || prod[PROD_W-2]))
        else $error("product below normalized range");
    end
  end
endmodule

// File: rtl/bf16_norm_pack.sv
module bf16_norm_pack #(
  parameter int EXP_W = bf16_mul_pkg::DEF_EXP_W,
  parameter int MAN_W = bf16_mul_pkg::DEF_MAN_W,
  localparam int WIDTH  = 1 + EXP_W + MAN_W,
  localparam int SIG_W  = MAN_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int SUM_W  = EXP_W + 2,
  localparam int BIAS   = bf16_mul_pkg::exp_bias(EXP_W),
  localparam int EXP_MAX = (1 << EXP_W) - 1
) (
  input  logic              sign,
  input  logic [EXP_W-1:0]  exp_a,
  input  logic [EXP_W-1:0]  exp_b,
  input  logic              any_zero,
  input  logic [PROD_W-1:0] prod,
  output logic [WIDTH-1:0]  result
);
  logic                    carry;
  logic [MAN_W-1:0]        man_sel;
  logic signed [SUM_W-1:0] exp_final;
  logic                    flush, saturate;

  always_comb begin
    carry     = prod[PROD_W-1];
    man_sel   = carry ? prod[PROD_W-2 -: MAN_W] : prod[PROD_W-3 -: MAN_W];
    exp_final = $signed(SUM_W'(exp_a)) + $signed(SUM_W'(exp_b))
              - $signed(SUM_W'(BIAS)) + $signed(SUM_W'(carry));
    flush     = any_zero || (exp_final <= 0);
    saturate  = !flush && (exp_final >= $signed(SUM_W'(EXP_MAX)));
    if (flush)
      result = {sign, {(EXP_W + MAN_W){1'b0}}};
    else if (saturate)
      result = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else
      result = {sign, exp_final[EXP_W-1:0], man_sel};
  end

  // R4: kept significand never exceeds the exact product and misses it by less than one dropped ulp
  logic [PROD_W-1:0] kept_full;
  always_comb begin
    kept_full = carry ? (PROD_W'({1'b1, man_sel}) << SIG_W)
                      : (PROD_W'({1'b1, man_sel}) << MAN_W);
    if (!$isunknown(prod) && prod[PROD_W-1:PROD_W-2] != 2'b00) begin
      assert_truncate_R4: assert (kept_full <= prod &&
                                  (prod - kept_full) < (carry ? PROD_W'(1 << SIG_W)
                                                              : PROD_W'(1 << MAN_W)))
        else $error("mantissa is not a truncation of the product");
    end
  end

  // R6, R7: packed output has no subnormal and no NaN pattern
  always_comb begin
    if (!$isunknown(result)) begin
      assert_no_subnormal_R6: assert (result[WIDTH-2 -: EXP_W] != '0 ||
                                      result[MAN_W-1:0] == '0)
        else $error("subnormal pattern produced");
      assert_inf_clean_R7: assert (result[WIDTH-2 -: EXP_W] != {EXP_W{1'b1}} ||
                                   result[MAN_W-1:0] == '0)
        else $error("NaN pattern produced");
    end
  end
endmodule

// File: rtl/bf16_multiplier.sv
module bf16_multiplier #(
  parameter int EXP_W = bf16_mul_pkg::DEF_EXP_W,
  parameter int MAN_W = bf16_mul_pkg::DEF_MAN_W,
  localparam int WIDTH  = 1 + EXP_W + MAN_W,
  localparam int SIG_W  = MAN_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int N_OPND = 2
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0]  opnd    [N_OPND];
  logic              sgn     [N_OPND];
  logic [EXP_W-1:0]  expo    [N_OPND];
  logic [SIG_W-1:0]  sig     [N_OPND];
  logic              zro     [N_OPND];
  logic [PROD_W-1:0] prod;

  assign opnd[0] = a;
  assign opnd[1] = b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_unpack
    bf16_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .word    (opnd[g]),
      .sign    (sgn[g]),
      .expo    (expo[g]),
      .sig     (sig[g]),
      .is_zero (zro[g])
    );
  end

  bf16_sig_mult #(.SIG_W(SIG_W)) u_mult (
    .sig_a (sig[0]),
    .sig_b (sig[1]),
    .prod  (prod)
  );

  bf16_norm_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
    .sign     (sgn[0] ^ sgn[1]),
    .exp_a    (expo[0]),
    .exp_b    (expo[1]),
    .any_zero (zro[0] | zro[1]),
    .prod     (prod),
    .result   (result)
  );

  always_comb begin
    if (!$isunknown({a, b, result})) begin
      assert_sign_R1: assert (result[WIDTH-1] == (a[WIDTH-1] ^ b[WIDTH-1]))
        else $error("sign mismatch");
      assert_zero_operand_R5: assert (!(a[WIDTH-2 -: EXP_W] == '0 || b[WIDTH-2 -: EXP_W] == '0) ||
                                      result[WIDTH-2:0] == '0)
        else $error("zero operand gave nonzero magnitude");
    end
  end
endmodule

// File: tb/bf16_multiplier_test.sv
module bf16_multiplier_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int N_RANDOM   = 4000;

  logic        clk = 1'b0;
  logic [15:0] a = 16'h0000;
  logic [15:0] b = 16'h0000;
  logic [15:0] result;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bf16_multiplier uut (.a(a), .b(b), .result(result));

  // Independent integer model of R1..R7
  function automatic logic [15:0] model(input logic [15:0] x, input logic [15:0] y,
                                        output string tag);
    int ex, ey, p, e, m;
    logic s;
    s  = x[15] ^ y[15];
    ex = int'(x[14:7]);
    ey = int'(y[14:7]);
    if (ex == 0 || ey == 0) begin tag = "R5"; return {s, 15'h0}; end
    p = (128 + int'(x[6:0])) * (128 + int'(y[6:0]));
    e = ex + ey - 127;
    if (p >= 32768) begin e = e + 1; m = (p >> 8) & 127; tag = "R3"; end
    else begin m = (p >> 7) & 127; tag = "R2"; end
    if (e <= 0)   begin tag = "R6"; return {s, 15'h0}; end
    if (e >= 255) begin tag = "R7"; return {s, 8'hFF, 7'h0}; end
    return {s, e[7:0], m[6:0]};
  endfunction

  task automatic check(input logic [15:0] x, input logic [15:0] y,
                       input logic [15:0] exp_v, input string req);
    @(negedge clk);
    a = x;
    b = y;
    #1;
    n_checks++;
    if (result !== exp_v) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, x, y, result, exp_v);
    end
  endtask

  initial begin
    // reset-like idle state: both inputs zero give positive zero (R5)
    #1;
    n_checks++;
    if (result !== 16'h0000) begin
      n_fail++;
      $display("FAIL R5 idle actual=%h expected=%h", result, 16'h0000);
    end
    check(16'h3F80, 16'h3F80, 16'h3F80, "R2 one times one");
    check(16'h3FC0, 16'h3FC0, 16'h4010, "R3 1.5 squared normalizes");
    check(16'hC000, 16'h4040, 16'hC0C0, "R1 negative times positive");
    check(16'hC000, 16'hC040, 16'h40C0, "R1 negative times negative");
    check(16'h3F81, 16'h3F81, 16'h3F82, "R4 low product bits truncated");
    check(16'h3FFF, 16'h3FFF, 16'h407E, "R4 truncation on normalized path");
    check(16'h8000, 16'h4000, 16'h8000, "R5 negative zero operand");
    check(16'h007F, 16'hC000, 16'h8000, "R5 zero exponent with mantissa");
    check(16'h0080, 16'h8080, 16'h8000, "R6 deep underflow");
    check(16'h1F80, 16'h2000, 16'h0000, "R6 final exponent exactly zero");
    check(16'h1FC0, 16'h2040, 16'h0090, "R6 carry lifts exponent to one");
    check(16'h7F00, 16'h4000, 16'h7F80, "R7 exponent sum 255");
    check(16'hFF00, 16'h4000, 16'hFF80, "R7 negative infinity");
    check(16'h7F00, 16'h3F80, 16'h7F00, "R7 exponent 254 kept");
    check(16'h7F40, 16'h3FC0, 16'h7F80, "R7 carry pushes 254 to infinity");

    void'($urandom(32'h5EED_0BF1));
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [15:0] x, y, ev;
      string tag;
      x = 16'($urandom());
      y = 16'($urandom());
      if (i % 8 == 0) y[14:7] = 8'd127 - x[14:7] + 8'($urandom_range(0, 2));
      ev = model(x, y, tag);
      check(x, y, ev, {tag, " random"});
      n_checks++;
      if (result[15] !== (x[15] ^ y[15])) begin
        n_fail++;
        $display("FAIL R1 random sign actual=%b expected=%b", result[15], x[15] ^ y[15]);
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule